// File: doc/BRIEF.md
# Table-Driven Binary Keying Carrier Modulator

This block turns a slow serial bit stream into a sampled sinusoidal carrier that is keyed by the data. A free-running divider on the system clock sets the sample rate. On each sample tick the block steps a pointer through one full sine period of 32 entries. It then emits one signed 12-bit sample, shaped by the bit currently being sent. A mode input selects the keying. Phase keying sends the carrier unchanged for a one and inverted for a zero. Amplitude keying sends the carrier for a one and silence for a zero.

One data bit spans exactly one carrier period of 32 samples. The bit is taken at the first sample of each period and held for the whole period, so every phase or amplitude change falls on a period boundary. A data-advance strobe goes out with the last sample of each period, which tells the upstream source to present its next bit. The sine samples come from a quarter-wave table that is folded by symmetry. Entry k equals round(2047·sin(2πk/32)).

Top module: `carrier_keyer`

## Requirements
- R1: While reset is asserted, `sample_out` is 0 and both strobes are low. The first sample after reset release is table entry 0.
- R2: `sample_valid` is a one-cycle pulse. It is high once every `SYS_PER_SAMPLE` clock cycles (the parameter is at least 2, default 64).
- R3: `sample_out` changes only in a cycle where `sample_valid` is high. It holds its value in every other cycle.
- R4: Successive samples step through table entries 0, 1, …, 31 and then wrap to 0. Entry k has the value round(2047·sin(2πk/32)), for example 0, 399, 783, 1137, 1447, 1702, 1891, 2008, 2047 for k = 0..8.
- R5: With `mode_sel` = 0 (phase keying), a held bit of 1 outputs the table entry. A held bit of 0 outputs its two's-complement negation.
- R6: With `mode_sel` = 1 (amplitude keying), a held bit of 1 outputs the table entry. A held bit of 0 outputs 0.
- R7: `data_bit` is sampled only on the tick that produces entry 0, and that value is used for all 32 samples of the period. Changes to `data_bit` at any other time do not affect the output until the next entry 0.
- R8: `bit_advance` is high exactly in the cycle when `sample_valid` carries entry 31, and it is low at all other times.
- R9: `sample_out` never takes the code -2048. Negating the most negative code gives +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_bit | input | 1 | Serial data bit to transmit |
| mode_sel | input | 1 | 0 = phase keying, 1 = amplitude keying |
| sample_out | output | 12 | Signed modulated carrier sample |
| sample_valid | output | 1 | One-cycle pulse with each new sample |
| bit_advance | output | 1 | Pulse with the last sample of a period; request for the next bit |

## Verification
The bench builds the block with `SYS_PER_SAMPLE` = 4 instead of 64. Each data period then takes 128 clocks rather than 2048, so the run covers well over a hundred full carrier periods. That span includes every table entry under both keying modes and both bit values, repeated wraps from entry 31 to 0, and data toggles in the middle of a period that must be ignored. A reset in the middle of the run confirms that the pointer restarts at entry 0 and that the divider spacing is correct from the first tick after release.

// File: rtl/keyer_pkg.sv
package keyer_pkg;
  localparam int SAMPLE_W  = 12;
  localparam int PTR_W     = 5;
  localparam int DEPTH     = 1 << PTR_W;
  localparam int QIDX_W    = PTR_W - 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  typedef enum logic {
    KEY_PHASE = 1'b0,
    KEY_AMPL  = 1'b1
  } key_mode_e;

  localparam sample_t SAMPLE_MAX = sample_t'((1 << (SAMPLE_W-1)) - 1);
  localparam sample_t SAMPLE_MIN = sample_t'(-(1 << (SAMPLE_W-1)));
endpackage

// File: rtl/keyer_reset_sync.sv
module keyer_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/keyer_rate_gen.sv
module keyer_rate_gen #(
  parameter int DIV   = 64,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [PTR_W-1:0] ptr,
  output logic             last
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    tick  = (cnt_q == CNT_W'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
    ptr_d = tick ? ptr_q + PTR_W'(1) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign ptr  = ptr_q;
  assign last = (ptr_q == '1);
endmodule

// File: rtl/keyer_sine_rom.sv
module keyer_sine_rom
  import keyer_pkg::*;
(
  input  logic [PTR_W-1:0] ptr,
  output sample_t          tone
);
  logic [1:0]        quadrant;
  logic [QIDX_W-1:0] step;
  logic [QIDX_W:0]   qidx;
  sample_t           mag;

  always_comb begin
    quadrant = ptr[PTR_W-1 -: 2];
    step     = ptr[QIDX_W-2:0] == '0 ? '0 : {1'b0, ptr[QIDX_W-2:0]};
    qidx     = quadrant[0] ? (QIDX_W+1)'(DEPTH/4) - {1'b0, step}
                           : {1'b0, step};
    case (qidx)
      5'd0:    mag = sample_t'(0);
      5'd1:    mag = sample_t'(399);
      5'd2:    mag = sample_t'(783);
      5'd3:    mag = sample_t'(1137);
      5'd4:    mag = sample_t'(1447);
      5'd5:    mag = sample_t'(1702);
      5'd6:    mag = sample_t'(1891);
      5'd7:    mag = sample_t'(2008);
      5'd8:    mag = sample_t'(2047);
      default: mag = sample_t'(0);
    endcase
    tone = quadrant[1] ? -mag : mag;
  end
endmodule

// File: rtl/keyer_mapper.sv
module keyer_mapper
  import keyer_pkg::*;
(
  input  sample_t   tone,
  input  logic      bit_val,
  input  key_mode_e mode,
  output sample_t   keyed
);
  always_comb begin
    if (bit_val)                keyed = tone;
    else if (mode == KEY_AMPL)  keyed = '0;
    else if (tone == SAMPLE_MIN) keyed = SAMPLE_MAX;
    else                        keyed = -tone;
  end
endmodule

// File: rtl/carrier_keyer.sv
module carrier_keyer
  import keyer_pkg::*;
#(
  parameter int SYS_PER_SAMPLE = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_bit,
  input  logic                mode_sel,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid,
  output logic                bit_advance
);
  logic             rst_core_n;
  logic             tick;
  logic             last;
  logic [PTR_W-1:0] ptr;
  sample_t          tone;
  sample_t          keyed;
  logic             use_bit;

  logic    held_q, held_d;
  sample_t sample_q, sample_d;
  logic    valid_q, valid_d;
  logic    adv_q, adv_d;

  keyer_reset_sync i_reset_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  keyer_rate_gen #(.DIV(SYS_PER_SAMPLE), .PTR_W(PTR_W)) i_rate_gen (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick),
    .ptr   (ptr),
    .last  (last)
  );

  keyer_sine_rom i_sine_rom (
    .ptr  (ptr),
    .tone (tone)
  );

  keyer_mapper i_mapper (
    .tone    (tone),
    .bit_val (use_bit),
    .mode    (key_mode_e'(mode_sel)),
    .keyed   (keyed)
  );

  always_comb begin
    use_bit  = (ptr == '0) ? data_bit : held_q;
    held_d   = (tick && ptr == '0) ? data_bit : held_q;
    sample_d = tick ? keyed : sample_q;
    valid_d  = tick;
    adv_d    = tick && last;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      held_q   <= 1'b0;
      sample_q <= '0;
      valid_q  <= 1'b0;
      adv_q    <= 1'b0;
    end else begin
      held_q   <= held_d;
      sample_q <= sample_d;
      valid_q  <= valid_d;
      adv_q    <= adv_d;
    end
  end

  assign sample_out   = sample_q;
  assign sample_valid = valid_q;
  assign bit_advance  = adv_q;
endmodule

// File: rtl/carrier_keyer_chk.sv
module carrier_keyer_chk #(
  parameter int DIV = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] sample_out,
  input logic        sample_valid,
  input logic        bit_advance
);
  localparam int GAP_W = $clog2(DIV) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [4:0]       strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      strobe_q <= '0;
    end else begin
      if (sample_valid) begin
        gap_q    <= '0;
        seen_q   <= 1'b1;
        strobe_q <= strobe_q + 5'd1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  // R2
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && seen_q |-> gap_q == GAP_W'(DIV - 1));

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample_out));

  // R8
  advance_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_advance |-> sample_valid && strobe_q == 5'd31);

  // R8
  advance_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && strobe_q == 5'd31 |-> bit_advance);

  // R9
  always @(posedge clk) begin
    if (rst_n) begin
      no_min_code_chk: assert (sample_out != 12'h800);
    end
  end
endmodule

bind carrier_keyer carrier_keyer_chk #(.DIV(SYS_PER_SAMPLE)) i_carrier_keyer_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_out   (sample_out),
  .sample_valid (sample_valid),
  .bit_advance  (bit_advance)
);

// File: tb/test_carrier_keyer.sv
`timescale 1ns/1ps
module test_carrier_keyer;
  localparam int DIV = 4;

  logic        clk;
  logic        rst_n;
  logic        data_bit;
  logic        mode_sel;
  logic [11:0] sample_out;
  logic        sample_valid;
  logic        bit_advance;

  int n_checks;
  int n_fail;

  carrier_keyer #(.SYS_PER_SAMPLE(DIV)) i_carrier_keyer (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_bit     (data_bit),
    .mode_sel     (mode_sel),
    .sample_out   (sample_out),
    .sample_valid (sample_valid),
    .bit_advance  (bit_advance)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int tone_of(int k);
    real r;
    r = 2047.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int keyed_of(int k, logic b, logic m);
    int t;
    t = tone_of(k);
    if (b) return t;
    if (m) return 0;
    return -t;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(10 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  int  strobe_n;
  int  gap;
  bit  first;
  int  last_sample;
  logic latched;

  task automatic restart_model();
    strobe_n    = 0;
    gap         = 0;
    first       = 1'b1;
    last_sample = 0;
  endtask

  task automatic drive_directed(int p);
    case (p)
      0: begin data_bit = 1'b1; mode_sel = 1'b0; end
      1: begin data_bit = 1'b0; mode_sel = 1'b0; end
      2: begin data_bit = 1'b1; mode_sel = 1'b1; end
      default: begin data_bit = 1'b0; mode_sel = 1'b1; end
    endcase
  endtask

  task automatic run_cycles(int ncyc, bit randomize_in);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      gap++;
      if (sample_valid) begin
        int k;
        int exp;
        int act;
        k   = strobe_n % 32;
        act = $signed(sample_out);
        if (k == 0) latched = data_bit;
        exp = keyed_of(k, latched, mode_sel);
        if (strobe_n == 0) check(k == 0 && act == 0, "R1 first sample is entry 0", act, 0);
        if (mode_sel == 1'b0)
          check(act == exp, latched ? "R4 R5 phase keying bit 1" : "R5 phase keying bit 0", act, exp);
        else
          check(act == exp, latched ? "R4 R6 amplitude keying bit 1" : "R6 amplitude keying bit 0", act, exp);
        if (k != 0 && data_bit != latched)
          check(act == exp, "R7 mid-period data ignored", act, exp);
        check(act != -2048, "R9 no most negative code", act, 2047);
        if (!first) check(gap == DIV, "R2 strobe spacing", gap, DIV);
        check(bit_advance == (k == 31), "R8 advance with entry 31", int'(bit_advance), int'(k == 31));
        first       = 1'b0;
        gap         = 0;
        last_sample = act;
        strobe_n++;
        if (!randomize_in && k == 31) drive_directed(strobe_n / 32);
      end else begin
        check($signed(sample_out) == last_sample, "R3 sample held between strobes",
              $signed(sample_out), last_sample);
        check(bit_advance == 1'b0, "R8 advance low without strobe", int'(bit_advance), 0);
      end
      if (randomize_in) begin
        if ($urandom % 3 == 0)  data_bit = ~data_bit;
        if ($urandom % 97 == 0) mode_sel = ~mode_sel;
      end
    end
  endtask

  task automatic reset_phase();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sample_out == 12'd0, "R1 reset sample", $signed(sample_out), 0);
      check(sample_valid == 1'b0 && bit_advance == 1'b0, "R1 reset strobes",
            int'({sample_valid, bit_advance}), 0);
    end
    restart_model();
    rst_n = 1'b1;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v   = $urandom(32'd2024);
    n_checks = 0;
    n_fail   = 0;
    latched  = 1'b0;
    data_bit = 1'b1;
    mode_sel = 1'b0;
    restart_model();
    rst_n = 1'b0;
    @(negedge clk);
    reset_phase();
    drive_directed(0);
    run_cycles(4 * 32 * DIV + 8, 1'b0);
    run_cycles(9000, 1'b1);
    @(negedge clk);
    reset_phase();
    data_bit = 1'b0;
    mode_sel = 1'b0;
    run_cycles(9000, 1'b1);
    finish_run();
  end
endmodule